// File: doc/BRIEF.md
# Frequency Band Residency Counter

This block measures how long a clock domain spends at or above each of several programmable operating frequencies. The present frequency ratio comes in on an 8-bit input, in steps of 100 MHz (0x20 stands for 3.2 GHz), and may change on any cycle. One 32-bit filter word holds a one-byte threshold for each of four bands. In every cycle where counting is enabled, a band fires when the ratio is at least that band's threshold.

Each band has two outputs. The first is a single-cycle count-enable flag that can drive an external performance counter. The second is a private residency counter. Bands are independent and may overlap, so a high frequency can satisfy several bands in the same cycle.

Top module: `freq_band_residency`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, every residency counter becomes zero at that edge.
- R2: Band b uses filter bits [8b+7:8b] as its threshold: band 0 in [7:0], band 1 in [15:8], band 2 in [23:16], band 3 in [31:24]. `band_hit[b]` is 1 in the same cycle exactly when `enable` is 1 and `freq_ratio` is greater than or equal to that threshold, with equality counting.
- R3: When `enable` is 0, every `band_hit` bit is 0 and no residency counter changes.
- R4: A residency counter grows by exactly 1 at each rising edge that follows a cycle with its `band_hit` bit set, and keeps its value otherwise.
- R5: A threshold of zero makes its band fire on every enabled cycle, whatever the ratio.
- R6: A residency counter that holds all ones wraps to zero on its next increment and then keeps counting.
- R7: Bands are evaluated independently, so several bands can fire in one cycle. A band whose threshold is not above another band's threshold fires whenever that other band fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the measured domain |
| rst_n | input | 1 | Synchronous active-low reset; clears the residency counters |
| enable | input | 1 | Counting window; bands fire only while high |
| band_filter | input | NUM_BANDS*THR_W (32) | Packed band thresholds, one byte per band, band 0 in the lowest byte |
| freq_ratio | input | THR_W (8) | Present frequency ratio in 100 MHz steps |
| band_hit | output | NUM_BANDS (4) | Per-band count-enable flag for the present cycle |
| band_count | output | NUM_BANDS*CNT_W (192) | Per-band residency counters, band 0 in the lowest CNT_W bits |

## Verification
The ratio input is swept across all 256 values under several filter words. One word has thresholds rising with band number and another has them falling, which tells apart a correct byte-to-band mapping from a swapped one. A word with all thresholds equal shows that bands fire together and that equality counts. A word mixing zero, 0xFF and mid-range values exercises the extreme thresholds. One sweep is run with `enable` low to show that it gates both flags and counters. A narrow counter build is then driven past its maximum with a zero threshold to show the wrap. Counter totals after each sweep are compared against tallies built from the swept values, which would expose double or missed counts.

// File: rtl/fbr_pkg.sv
// Package: shared defaults and helper for the frequency band residency block.
// Assumes thresholds and the frequency ratio share one unsigned encoding.
package fbr_pkg;
    localparam int DEF_NUM_BANDS = 4;
    localparam int DEF_THR_W     = 8;
    localparam int DEF_CNT_W     = 48;

    // Unsigned at-or-above comparison used by every band.
    function automatic logic at_or_above(input logic [DEF_THR_W-1:0] ratio,
                                         input logic [DEF_THR_W-1:0] thr);
        return ratio >= thr;
    endfunction
endpackage

// File: rtl/fbr_band_compare.sv
// Module: one band's qualifier. Fires when counting is enabled and the
// ratio is at or above the band threshold. Purely combinational.
// Assumes THR_W matches the package default width.
module fbr_band_compare
    import fbr_pkg::*;
#(
    parameter int THR_W = DEF_THR_W
) (
    input  logic             enable,
    input  logic [THR_W-1:0] ratio,
    input  logic [THR_W-1:0] thr,
    output logic             hit
);
    // Qualify the comparison with the counting window.
    always_comb begin
        hit = enable && at_or_above(ratio, thr);
    end
endmodule

// File: rtl/fbr_residency_counter.sv
// Module: one band's residency counter. Adds one per qualified cycle,
// wraps silently at full scale, and clears on synchronous active-low reset.
// Assumes inc is stable before the rising edge.
module fbr_residency_counter #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Clear on reset, otherwise accumulate qualified cycles modulo 2^CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + ONE;
        end
    end
endmodule

// File: rtl/freq_band_residency.sv
// Module: top of the frequency band residency counter. Splits the packed
// filter into per-band thresholds, qualifies each band against the present
// ratio and keeps one residency counter per band.
// Assumes freq_ratio is synchronous to clk.
module freq_band_residency
    import fbr_pkg::*;
#(
    parameter int NUM_BANDS = DEF_NUM_BANDS,
    parameter int THR_W     = DEF_THR_W,
    parameter int CNT_W     = DEF_CNT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic [NUM_BANDS*THR_W-1:0] band_filter,
    input  logic [THR_W-1:0]           freq_ratio,
    output logic [NUM_BANDS-1:0]       band_hit,
    output logic [NUM_BANDS*CNT_W-1:0] band_count
);
    localparam int FILTER_W = NUM_BANDS * THR_W;

    logic [THR_W-1:0] thr_slice [NUM_BANDS];

    for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
        // Pick this band's byte out of the packed filter word.
        always_comb begin
            thr_slice[b] = band_filter[b*THR_W +: THR_W];
        end

        fbr_band_compare #(.THR_W(THR_W)) u_cmp (
            .enable (enable),
            .ratio  (freq_ratio),
            .thr    (thr_slice[b]),
            .hit    (band_hit[b])
        );

        fbr_residency_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (band_hit[b]),
            .count  (band_count[b*CNT_W +: CNT_W])
        );
    end

    // Elaboration guard on the packed filter layout.
    initial begin
        if (FILTER_W != $bits(band_filter)) $error("filter width mismatch");
    end
endmodule

// File: rtl/fbr_checker.sv
// Module: assertion checker bound to freq_band_residency. Watches ports only.
module fbr_checker #(
    parameter int NUM_BANDS = 4,
    parameter int THR_W     = 8,
    parameter int CNT_W     = 48
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       enable,
    input logic [NUM_BANDS*THR_W-1:0] band_filter,
    input logic [NUM_BANDS-1:0]       band_hit,
    input logic [NUM_BANDS*CNT_W-1:0] band_count
);
    // R3
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> band_hit == '0);

    for (genvar b = 0; b < NUM_BANDS; b++) begin : g_chk
        // R1
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> band_count[b*CNT_W +: CNT_W] == '0);

        // R4
        step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> band_count[b*CNT_W +: CNT_W] ==
                CNT_W'($past(band_count[b*CNT_W +: CNT_W]) + CNT_W'($past(band_hit[b]))));

        // R5
        zero_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (enable && band_filter[b*THR_W +: THR_W] == '0) |-> band_hit[b]);

        for (genvar o = 0; o < NUM_BANDS; o++) begin : g_pair
            if (o != b) begin : g_ne
                // R7
                band_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (band_filter[b*THR_W +: THR_W] <= band_filter[o*THR_W +: THR_W]
                     && band_hit[o]) |-> band_hit[b]);
            end
        end
    end
endmodule

bind freq_band_residency fbr_checker #(
    .NUM_BANDS (NUM_BANDS),
    .THR_W     (THR_W),
    .CNT_W     (CNT_W)
) u_fbr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .band_filter (band_filter),
    .band_hit    (band_hit),
    .band_count  (band_count)
);

// File: tb/freq_band_residency_tb.sv
module freq_band_residency_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int TW = 8;
    localparam int CW = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic              rst_n;
    logic              enable;
    logic [NB*TW-1:0]  band_filter;
    logic [TW-1:0]     freq_ratio;
    logic [NB-1:0]     band_hit;
    logic [NB*CW-1:0]  band_count;

    int total = 0;
    int bad   = 0;
    int exp_cnt [NB];
    bit done  = 0;

    freq_band_residency #(.NUM_BANDS(NB), .THR_W(TW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .band_filter(band_filter),
        .freq_ratio(freq_ratio), .band_hit(band_hit), .band_count(band_count)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge and check the flags combinationally (R2, R3, R7).
    task automatic apply(input logic en, input logic [TW-1:0] f);
        logic [NB-1:0] e;
        @(negedge clk);
        enable = en;
        freq_ratio = f;
        #1;
        for (int b = 0; b < NB; b++) begin
            e[b] = en && (int'(f) >= int'(band_filter[b*TW +: TW]));
            if (en) chk(band_hit[b] == e[b], "R2", band_hit[b], e[b]);
            else    chk(band_hit[b] == 1'b0, "R3", band_hit[b], 0);
            if (e[b]) exp_cnt[b] = (exp_cnt[b] + 1) % (1 << CW);
        end
        if ($countones(e) > 1) chk(band_hit == e, "R7", band_hit, e);
    endtask

    // Stop counting, then compare counters with the tallies (R4 and caller tag).
    task automatic check_counts(input string req);
        @(negedge clk);
        enable = 1'b0;
        #1;
        for (int b = 0; b < NB; b++)
            chk(band_count[b*CW +: CW] == CW'(exp_cnt[b]), req,
                band_count[b*CW +: CW], exp_cnt[b]);
    endtask

    // Clear counters through a one-cycle reset pulse (R1).
    task automatic pulse_reset();
        @(negedge clk);
        enable = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int b = 0; b < NB; b++) begin
            exp_cnt[b] = 0;
            chk(band_count[b*CW +: CW] == '0, "R1", band_count[b*CW +: CW], 0);
        end
    endtask

    task automatic sweep(input logic [NB*TW-1:0] filt, input logic en, input string req);
        @(negedge clk);
        band_filter = filt;
        for (int f = 0; f < 256; f++) apply(en, TW'(f));
        check_counts(req);
    endtask

    initial begin
        rst_n = 1'b0;
        enable = 1'b0;
        band_filter = '0;
        freq_ratio = '0;
        for (int b = 0; b < NB; b++) exp_cnt[b] = 0;
        repeat (3) @(negedge clk);
        #1;
        for (int b = 0; b < NB; b++)
            chk(band_count[b*CW +: CW] == '0, "R1", band_count[b*CW +: CW], 0);
        rst_n = 1'b1;

        sweep(32'h40302010, 1'b1, "R4");   // rising thresholds, byte mapping
        sweep(32'h10203040, 1'b1, "R4");   // falling thresholds, swapped mapping shows
        sweep(32'h20202020, 1'b1, "R7");   // equal thresholds, all fire together
        sweep(32'hFF800100, 1'b1, "R5");   // zero, one, mid and full-scale thresholds
        sweep(32'h01010101, 1'b0, "R3");   // disabled: no flag, no count

        pulse_reset();

        // R6: zero thresholds count every cycle past full scale of the narrow counter
        @(negedge clk);
        band_filter = '0;
        for (int i = 0; i < (1 << CW) + 6; i++) apply(1'b1, TW'(i * 7));
        check_counts("R6");
        for (int b = 0; b < NB; b++)
            chk(band_count[b*CW +: CW] == CW'(6), "R6", band_count[b*CW +: CW], 6);

        pulse_reset();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule